// File: doc/BRIEF.md
# I2C Slave Address Recognizer (7-bit / 10-bit)

This block sits on an I2C bus and watches every transfer from its START condition. It decides whether the local controller is the target of that transfer. SCL and SDA are oversampled by the system clock through a short synchronizer. The block shifts in the address byte or bytes and compares them with its own configured address. When they match, it pulls SDA low for the acknowledge bit. It also emits a one-cycle match pulse and holds the requested direction until the next bus condition.

Two address schemes are supported, selected by a mode input. In 7-bit mode, the upper seven bits of the first byte are compared with the low seven bits of the own address. In 10-bit mode, two bytes are needed. The first byte is a fixed `11110` prefix, followed by address bits 9..8 (taken from a separate three-bit high-address field) and a write direction bit. The second byte carries address bits 7..0. Separately, a first byte of all zeros can be accepted as a general call when the enable input allows it.

Once the address phase is settled, the block releases SDA. It then ignores the bus until the next START. Any STOP returns it to idle. Data bytes, clock stretching and the 10-bit read via repeated START are handled elsewhere.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset `sda_pull`, `match`, `rd_req` and `gcall` are all 0.
- R2: With `ext10_en`=0, a first byte whose bits 7..1 equal `addr_lo[6:0]` (and are not all zero) is acknowledged: `sda_pull` is 1 through the ninth SCL high phase, `match` pulses, and `rd_req` takes the byte's bit 0 (1 = read).
- R3: A first byte that does not qualify is not acknowledged and gives no match. Every later byte is then ignored until the next START, even one that equals the own address.
- R4: With `ext10_en`=1, a first byte equal to {`11110`, `addr_hi[1:0]`, 0} is acknowledged without a match pulse. A following byte equal to `addr_lo[7:0]` is then acknowledged with a match pulse and `rd_req`=0. A different second byte is not acknowledged and gives no match. A first byte of that form with bit 0 = 1 is not acknowledged.
- R5: `addr_hi[2]` never affects recognition, and `addr_hi` has no effect in 7-bit mode.
- R6: A first byte 0x00 with `gcall_en`=1 is acknowledged with a match pulse, `gcall`=1 and `rd_req`=0, in either mode. With `gcall_en`=0 it is not acknowledged.
- R7: A first byte whose bits 7..1 are all zero never counts as an own-address match. So 0x01 is never acknowledged, and 0x00 is not acknowledged when `gcall_en`=0, even with `addr_lo[6:0]`=0.
- R8: A START or a STOP (SDA edge while SCL is high) clears `rd_req` and `gcall` and restarts recognition. A repeated START after a rejected byte allows a new address to be matched.
- R9: `sda_pull` changes only while SCL is low, and it is released after the ninth SCL falling edge of the acknowledged byte.
- R10: `match` is exactly one clock cycle wide per recognized address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| ext10_en | input | 1 | 0 = 7-bit scheme, 1 = 10-bit scheme |
| gcall_en | input | 1 | 1 = accept the general call byte 0x00 |
| addr_hi | input | 3 | Own address bits 10..8 (bits 9..8 used in 10-bit mode) |
| addr_lo | input | 8 | Own address bits 7..0 (bits 6..0 used in 7-bit mode) |
| sda_pull | output | 1 | 1 = drive SDA low (acknowledge) |
| match | output | 1 | One-cycle pulse when the address is recognized |
| rd_req | output | 1 | Requested direction of the matched transfer, 1 = read |
| gcall | output | 1 | The matched address was the general call |

## Verification
The bench checks the zero first byte in several settings: general call on and off, and an own address of zero. A design that folded the general call into the ordinary compare would acknowledge 0x00 or 0x01 when it must stay silent. In 10-bit mode it feeds a correct prefix followed by a wrong low byte, and also a prefix with the read bit set. A design that matched on the first byte alone, or ignored the direction bit, would acknowledge both. After a rejected byte it sends the own address without a new START, to catch a recognizer that re-arms on every byte. Finally, STOP and repeated START are checked to clear the direction and general-call flags, which a design that only cleared them on reset would leave set.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       ext10_en,
  input  logic       gcall_en,
  input  logic [2:0] addr_hi,
  input  logic [7:0] addr_lo,
  output logic       sda_pull,
  output logic       match,
  output logic       rd_req,
  output logic       gcall
);

  typedef enum logic [2:0] {S_IDLE, S_B1, S_A1, S_B2, S_A2} st_t;

  logic [SYNC-1:0] scl_s, sda_s;
  logic scl, sda, scl_q, sda_q;
  logic start_ev, stop_ev, rise, fall, full;
  logic [3:0] cnt;
  logic [7:0] shreg;
  st_t st;

  assign scl = scl_s[SYNC-1];
  assign sda = sda_s[SYNC-1];
  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;
  assign rise = scl & ~scl_q;
  assign fall = ~scl & scl_q;
  assign full = (cnt == 4'd8);

  logic is_gc, is_7b, is_10p, is_10l;
  assign is_gc  = gcall_en && (shreg == 8'h00);
  assign is_7b  = !ext10_en && (shreg[7:1] != 7'd0) && (shreg[7:1] == addr_lo[6:0]);
  assign is_10p = ext10_en && (shreg[7:3] == 5'b11110) && (shreg[2:1] == addr_hi[1:0]) && !shreg[0];
  assign is_10l = (shreg == addr_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC-2:0], scl_i};
      sda_s <= {sda_s[SYNC-2:0], sda_i};
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      sda_pull <= 1'b0;
      match    <= 1'b0;
      rd_req   <= 1'b0;
      gcall    <= 1'b0;
    end else begin
      match <= 1'b0;
      if (start_ev || stop_ev) begin
        st       <= start_ev ? S_B1 : S_IDLE;
        cnt      <= '0;
        sda_pull <= 1'b0;
        rd_req   <= 1'b0;
        gcall    <= 1'b0;
      end else begin
        unique case (st)
          S_B1, S_B2: begin
            if (rise && !full) begin
              shreg <= {shreg[6:0], sda};
              cnt   <= cnt + 4'd1;
            end else if (fall && full) begin
              cnt <= '0;
              if (st == S_B1) begin
                if (is_gc) begin
                  sda_pull <= 1'b1;
                  match    <= 1'b1;
                  gcall    <= 1'b1;
                  st       <= S_A2;
                end else if (is_7b) begin
                  sda_pull <= 1'b1;
                  match    <= 1'b1;
                  rd_req   <= shreg[0];
                  st       <= S_A2;
                end else if (is_10p) begin
                  sda_pull <= 1'b1;
                  st       <= S_A1;
                end else begin
                  st <= S_IDLE;
                end
              end else if (is_10l) begin
                sda_pull <= 1'b1;
                match    <= 1'b1;
                st       <= S_A2;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_A1: if (fall) begin
            sda_pull <= 1'b0;
            st       <= S_B2;
          end
          S_A2: if (fall) begin
            sda_pull <= 1'b0;
            st       <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_pull,
  input logic match,
  input logic rd_req,
  input logic gcall
);

  // R10
  match_width_chk: assert property (@(posedge clk) disable iff (!rst_n) match |=> !match);

  // R2
  match_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) match |-> sda_pull);

  // R6
  gcall_dir_chk: assert property (@(posedge clk) disable iff (!rst_n) gcall |-> !rd_req);

  // R6
  gcall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(gcall) |-> match);

  // R9
  pull_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_pull) |-> $past(!scl_s));

  // R9
  pull_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(sda_pull) |-> $past(!scl_s));

endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl), .sda_pull(sda_pull),
  .match(match), .rd_req(rd_req), .gcall(gcall)
);

// File: tb/sim_i2c_addr_match.sv
`timescale 1ns/1ps
module sim_i2c_addr_match;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic ext10_en = 1'b0, gcall_en = 1'b0;
  logic [2:0] addr_hi = '0;
  logic [7:0] addr_lo = '0;
  logic sda_pull, match, rd_req, gcall;
  logic sda_bus;
  int errs = 0, checks = 0, mcnt = 0, cyc = 0;

  assign sda_bus = sda_m & ~sda_pull;

  always #2.5 clk = ~clk;

  i2c_addr_match u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .ext10_en(ext10_en), .gcall_en(gcall_en), .addr_hi(addr_hi), .addr_lo(addr_lo),
    .sda_pull(sda_pull), .match(match), .rd_req(rd_req), .gcall(gcall)
  );

  always @(posedge clk) if (match) mcnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errs++; checks++;
      $display("FAIL watchdog: act=expired exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H/2); scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H/2); scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic xbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(H/2); sda_m = b[i]; tick(H/2);
      scl_m = 1'b1; tick(H); scl_m = 1'b0;
    end
    tick(H/2); sda_m = 1'b1; tick(H/2);
    scl_m = 1'b1; tick(H/2); ack = !sda_bus; tick(H/2); scl_m = 1'b0;
    tick(H);
    chk(sda_pull == 1'b0, "R9 release after ninth clock", int'(sda_pull), 0);
  endtask

  // 0 = reject, 1 = final match, 2 = 10-bit prefix accepted, 3 = general call
  function automatic int exp_b1(logic [7:0] b, logic e10, logic gce, logic [2:0] hi, logic [7:0] lo);
    if (gce && b == 8'h00) return 3;
    if (!e10) return (b[7:1] != 7'd0 && b[7:1] == lo[6:0]) ? 1 : 0;
    return (b[7:3] == 5'b11110 && b[2:1] == hi[1:0] && !b[0]) ? 2 : 0;
  endfunction

  task automatic run(input logic [7:0] b1, input logic [7:0] b2, input string tag);
    logic ack;
    int e, m0, exp_ack, exp_m, exp_rd, exp_gc;
    e = exp_b1(b1, ext10_en, gcall_en, addr_hi, addr_lo);
    m0 = mcnt;
    bus_start();
    xbyte(b1, ack);
    exp_ack = (e != 0) ? 1 : 0;
    chk(ack == exp_ack[0], {tag, " first ack"}, int'(ack), exp_ack);
    exp_m = (e == 1 || e == 3) ? 1 : 0;
    exp_rd = (e == 1) ? int'(b1[0]) : 0;
    exp_gc = (e == 3) ? 1 : 0;
    if (e == 2) begin
      chk(mcnt == m0, "R4 no match on prefix", mcnt - m0, 0);
      xbyte(b2, ack);
      exp_ack = (b2 == addr_lo) ? 1 : 0;
      exp_m = exp_ack;
      chk(ack == exp_ack[0], "R4 second ack", int'(ack), exp_ack);
    end
    chk(mcnt - m0 == exp_m, {tag, " R10 match pulses"}, mcnt - m0, exp_m);
    chk(int'(rd_req) == exp_rd, {tag, " R2 direction"}, int'(rd_req), exp_rd);
    chk(int'(gcall) == exp_gc, {tag, " R6 gcall flag"}, int'(gcall), exp_gc);
    bus_stop();
    chk(rd_req == 1'b0 && gcall == 1'b0, "R8 cleared by STOP", int'({rd_req, gcall}), 0);
  endtask

  initial begin
    logic ack;
    void'($urandom(32'd4711));
    tick(4);
    chk({sda_pull, match, rd_req, gcall} == 4'b0, "R1 reset state", int'({sda_pull, match, rd_req, gcall}), 0);
    rst_n = 1'b1;
    tick(4);

    // R2 7-bit write and read
    ext10_en = 0; gcall_en = 0; addr_lo = 8'h5A; addr_hi = 3'b101;
    run({7'h5A, 1'b0}, 8'h00, "R2 write");
    run({7'h5A, 1'b1}, 8'h00, "R2 read");
    // R5 addr_hi has no effect in 7-bit mode
    addr_hi = 3'b010;
    run({7'h5A, 1'b1}, 8'h00, "R5 7-bit hi change");

    // R3 mismatch then own address without a new START
    bus_start();
    xbyte({7'h11, 1'b0}, ack);
    chk(ack == 1'b0, "R3 mismatch nack", int'(ack), 0);
    xbyte({7'h5A, 1'b0}, ack);
    chk(ack == 1'b0, "R3 ignored until START", int'(ack), 0);
    // R8 repeated START re-arms
    bus_start();
    xbyte({7'h5A, 1'b1}, ack);
    chk(ack == 1'b1, "R8 repeated START match", int'(ack), 1);
    chk(rd_req == 1'b1, "R8 direction after repeated START", int'(rd_req), 1);
    bus_start();
    chk(rd_req == 1'b0, "R8 cleared by START", int'(rd_req), 0);
    bus_stop();

    // R7 zero address
    addr_lo = 8'h00; gcall_en = 0;
    run(8'h00, 8'h00, "R7 zero no gc");
    run(8'h01, 8'h00, "R7 zero read");
    // R6 general call both modes
    gcall_en = 1;
    run(8'h00, 8'h00, "R6 gc 7-bit");
    ext10_en = 1;
    run(8'h00, 8'h00, "R6 gc 10-bit");

    // R4 10-bit
    addr_hi = 3'b010; addr_lo = 8'hC3; gcall_en = 0;
    run(8'b11110_10_0, 8'hC3, "R4 match");
    run(8'b11110_10_0, 8'hC2, "R4 wrong low");
    run(8'b11110_10_1, 8'hC3, "R4 read prefix");
    run(8'b11110_01_0, 8'hC3, "R4 wrong hi");
    // R5 bit 10 ignored
    addr_hi = 3'b110;
    run(8'b11110_10_0, 8'hC3, "R5 bit10 set");

    // random mix
    for (int t = 0; t < 120; t++) begin
      logic [7:0] b1, b2;
      int sel;
      ext10_en = 1'($urandom);
      gcall_en = 1'($urandom);
      addr_hi = 3'($urandom);
      addr_lo = 8'($urandom);
      sel = int'($urandom % 8);
      if (sel < 2) b1 = 8'h00;
      else if (sel < 5) b1 = ext10_en ? {5'b11110, addr_hi[1:0], 1'b0} : {addr_lo[6:0], 1'($urandom)};
      else b1 = 8'($urandom);
      b2 = ($urandom % 2 == 0) ? addr_lo : 8'($urandom);
      run(b1, b2, "R2/R4/R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule